// File: doc/BRIEF.md
# Burst Write to TLP Segmenter

This block sits behind a memory-mapped write slave and turns each write burst into one or more PCIe memory-write packets on a ready/valid packet stream. Every packet is one header beat followed by its payload beats. The header beat carries a 3-dword header when the target address fits in 32 bits and a 4-dword header otherwise. Start-of-packet and end-of-packet flags frame the packet.

Each burst is cut at the configured maximum payload size and at every 4 KB address boundary. A short burst leaves as a short packet. Its length covers only the dwords between the first enabled dword of its first beat and the last enabled dword of its last beat. The first-dword and last-dword byte-enable fields of the header describe partial dwords, so the sender never pads.

The block collects a packet's beats in a local buffer, then emits the header and the payload. It holds off the slave with wait-request while it emits, so no write beat is lost. Bursts are never merged: each burst yields its own packets.

Top module: `burst_tlp_segmenter`

## Requirements
- R1: A burst whose count is 0 or greater than 32 beats is rejected. `s_burst_err` goes high for one cycle, in the cycle after its first beat is taken. All of its beats are taken and dropped (one beat for a count of 0), and no packet is produced.
- R2: One beat is 16 bytes of `s_writedata`. `s_address` and `s_burstcount` are sampled on a burst's first beat only. `s_address[3:0]` is ignored, and each later beat targets the previous beat address plus 16.
- R3: No packet carries more than the maximum payload: 128 bytes for `mps_sel`=0, 256 for 1, and 512 for 2 or 3. A longer burst is split, and each follow-on packet's address equals the previous packet's address plus the bytes it covered.
- R4: A burst no longer than the maximum payload that does not reach past a 4 KB boundary yields exactly one packet. Its length field is the count of dwords from the first enabled dword of the first beat to the last enabled dword of the last beat.
- R5: A packet ends after any beat whose address bits [11:4] are all ones, so no packet crosses a 4 KB boundary.
- R6: The header beat layout is fixed. Dword k sits at `m_data[32k+31:32k]`. In dword 0, bits [31:29] are the format (010 when the packet address is below 2^32, 011 otherwise), bits [28:24] are the type (00000) and bits [9:0] are the length in dwords. A 3-dword header has the address bits [31:2] in dword 2 and zero in dword 3. A 4-dword header has address bits [63:32] in dword 2 and [31:2] in dword 3.
- R7: In dword 1 of the header, bits [3:0] are the byte-enable nibble of the first enabled dword of the packet's first beat. Bits [7:4] are the nibble of the last enabled dword of its last beat, forced to 0000 when the length is 1. The packet address is the beat address plus 4 times the index of that first enabled dword.
- R8: The payload beats follow the header unchanged and in input order. `m_sop` is high on the header beat only and `m_eop` on the last payload beat only. Separate bursts never share a packet.
- R9: `s_waitrequest` is high exactly while a packet is being emitted. While `m_valid` is high and `m_ready` low, `m_data`, `m_sop` and `m_eop` hold.
- R10: During and right after reset, `m_valid`, `s_waitrequest` and `s_burst_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mps_sel | input | 2 | Maximum payload: 0=128 B, 1=256 B, 2/3=512 B; change only while idle |
| s_address | input | 64 | Byte address of the burst, sampled on its first beat |
| s_burstcount | input | 6 | Burst length in 16-byte beats, sampled on its first beat |
| s_write | input | 1 | Write beat present |
| s_writedata | input | 128 | Write data beat |
| s_byteenable | input | 16 | Byte enables of the beat |
| s_waitrequest | output | 1 | Slave stall; a beat is taken when `s_write` is high and this is low |
| s_burst_err | output | 1 | One-cycle pulse for a rejected burst |
| m_data | output | 128 | Header or payload beat |
| m_valid | output | 1 | Stream beat valid |
| m_sop | output | 1 | Header beat marker |
| m_eop | output | 1 | Last payload beat marker |
| m_ready | input | 1 | Stream sink ready |

## Verification
A packet's header beat is offered in the cycle after the slave beat that closes the packet is taken. Each payload beat follows one cycle after the previous beat is accepted. A rejection pulse appears one cycle after the first beat of a bad burst. The bench does not pin these results to fixed cycle numbers. A scoreboard queues the expected beats when a burst is driven, and it compares each beat in order as it is accepted, sampling at the falling edge under random back-pressure. Rejection pulses are counted at the falling edge and matched against the number of bad bursts.

// File: rtl/burst_tlp_segmenter.sv
module burst_tlp_segmenter #(
  parameter int MAX_BEATS = 32,
  parameter int CNT_W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mps_sel,
  input  logic [63:0]  s_address,
  input  logic [CNT_W-1:0] s_burstcount,
  input  logic         s_write,
  input  logic [127:0] s_writedata,
  input  logic [15:0]  s_byteenable,
  output logic         s_waitrequest,
  output logic         s_burst_err,
  output logic [127:0] m_data,
  output logic         m_valid,
  output logic         m_sop,
  output logic         m_eop,
  input  logic         m_ready
);
  localparam int IDX_W = $clog2(MAX_BEATS);
  localparam int PC_W  = IDX_W + 1;

  typedef enum logic [1:0] {COLLECT, HDR, DATA, DRAIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] left_q;
  logic [59:0]      baddr_q, pkt_baddr_q;
  logic [PC_W-1:0]  cnt_q;
  logic [IDX_W-1:0] rd_q;
  logic [15:0]      fbe_q, lbe_q;
  logic             err_q;
  logic [127:0]     buf_q [MAX_BEATS];

  logic             active, accept, bad, cut, last_rd, hi;
  logic [59:0]      in_baddr;
  logic [CNT_W-1:0] in_left;
  logic [PC_W-1:0]  mps_beats;
  logic [1:0]       f_idx, l_idx;
  logic [3:0]       fbe_n, lbe_n;
  logic [9:0]       len;
  logic [63:0]      pkt_addr;
  logic [31:0]      dw0, dw1;
  logic [127:0]     hdr;

  assign active        = left_q != '0;
  assign s_waitrequest = (st == HDR) || (st == DATA);
  assign accept        = s_write && !s_waitrequest;
  assign in_baddr      = active ? baddr_q : s_address[63:4];
  assign in_left       = active ? left_q  : s_burstcount;
  assign bad           = !active && (s_burstcount == '0 ||
                                     s_burstcount > CNT_W'(MAX_BEATS));
  assign mps_beats     = (mps_sel == 2'd0) ? PC_W'(MAX_BEATS / 4) :
                         (mps_sel == 2'd1) ? PC_W'(MAX_BEATS / 2) :
                                             PC_W'(MAX_BEATS);
  assign cut           = (in_left == CNT_W'(1)) ||
                         (cnt_q + 1'b1 == mps_beats) ||
                         (in_baddr[7:0] == 8'hff);

  always_comb begin
    f_idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (fbe_q[4*i +: 4] != 4'h0) f_idx = 2'(i);
    l_idx = 2'd3;
    for (int i = 0; i < 4; i++)
      if (lbe_q[4*i +: 4] != 4'h0) l_idx = 2'(i);
  end

  assign len      = 10'({cnt_q, 2'b00}) - 10'(f_idx) - 10'(2'd3 - l_idx);
  assign fbe_n    = fbe_q[4*f_idx +: 4];
  assign lbe_n    = (len == 10'd1) ? 4'h0 : lbe_q[4*l_idx +: 4];
  assign pkt_addr = {pkt_baddr_q, f_idx, 2'b00};
  assign hi       = pkt_addr[63:32] != 32'h0;
  assign dw0      = {hi ? 3'b011 : 3'b010, 5'b00000, 14'h0, len};
  assign dw1      = {24'h0, lbe_n, fbe_n};
  assign hdr      = hi ? {pkt_addr[31:0], pkt_addr[63:32], dw1, dw0}
                       : {32'h0, pkt_addr[31:0], dw1, dw0};

  assign last_rd     = PC_W'(rd_q) == cnt_q - 1'b1;
  assign m_valid     = (st == HDR) || (st == DATA);
  assign m_sop       = st == HDR;
  assign m_eop       = (st == DATA) && last_rd;
  assign m_data      = (st == HDR) ? hdr : buf_q[rd_q];
  assign s_burst_err = err_q;

  always_ff @(posedge clk)
    if (st == COLLECT && accept && !bad)
      buf_q[cnt_q[IDX_W-1:0]] <= s_writedata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= COLLECT;
      left_q      <= '0;
      baddr_q     <= '0;
      pkt_baddr_q <= '0;
      cnt_q       <= '0;
      rd_q        <= '0;
      fbe_q       <= '0;
      lbe_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        COLLECT: if (accept) begin
          if (bad) begin
            err_q <= 1'b1;
            if (s_burstcount > CNT_W'(1)) begin
              left_q <= s_burstcount - 1'b1;
              st     <= DRAIN;
            end
          end else begin
            if (cnt_q == '0) begin
              pkt_baddr_q <= in_baddr;
              fbe_q       <= s_byteenable;
            end
            lbe_q   <= s_byteenable;
            cnt_q   <= cnt_q + 1'b1;
            left_q  <= in_left - 1'b1;
            baddr_q <= in_baddr + 60'd1;
            if (cut) st <= HDR;
          end
        end
        DRAIN: if (s_write) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st <= COLLECT;
        end
        HDR: if (m_ready) begin
          rd_q <= '0;
          st   <= DATA;
        end
        DATA: if (m_ready) begin
          rd_q <= rd_q + 1'b1;
          if (last_rd) begin
            cnt_q <= '0;
            st    <= COLLECT;
          end
        end
        default: st <= COLLECT;
      endcase
    end
  end
endmodule

module burst_tlp_segmenter_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mps_sel,
  input logic         s_waitrequest,
  input logic [127:0] m_data,
  input logic         m_valid,
  input logic         m_sop,
  input logic         m_eop,
  input logic         m_ready
);
  logic        is4;
  logic [9:0]  hlen, lim;
  logic [11:0] lo12;

  assign is4  = m_data[31:29] == 3'b011;
  assign hlen = m_data[9:0];
  assign lo12 = is4 ? m_data[107:96] : m_data[75:64];
  assign lim  = (mps_sel == 2'd0) ? 10'd32 : (mps_sel == 2'd1) ? 10'd64 : 10'd128;

  AST_HDR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sop |-> (m_data[31:29] == 3'b010 || is4) && m_data[28:24] == 5'h0); // R6
  AST_WIDE_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sop && is4 |-> m_data[95:64] != 32'h0); // R6
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sop |-> hlen != 10'd0 && hlen <= lim); // R3
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sop |-> 14'(lo12) + 14'({hlen, 2'b00}) <= 14'd4096); // R5
  AST_SINGLE_DW_LAST_BE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sop && hlen == 10'd1 |-> m_data[39:36] == 4'h0); // R7
  AST_SOP_EOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_sop && m_eop)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)); // R9
  AST_STALL_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> s_waitrequest); // R9
endmodule

bind burst_tlp_segmenter burst_tlp_segmenter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mps_sel(mps_sel), .s_waitrequest(s_waitrequest),
  .m_data(m_data), .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop), .m_ready(m_ready)
);

// File: tb/burst_tlp_segmenter_bench.sv
`timescale 1ns/1ps
module burst_tlp_segmenter_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mps_sel;
  logic [63:0]  s_address;
  logic [5:0]   s_burstcount;
  logic         s_write;
  logic [127:0] s_writedata;
  logic [15:0]  s_byteenable;
  logic         s_waitrequest, s_burst_err;
  logic [127:0] m_data;
  logic         m_valid, m_sop, m_eop;
  logic         m_ready;

  typedef struct packed {logic sop; logic eop; logic [127:0] d;} item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, exp_err = 0, got_err = 0;
  bit bp = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  burst_tlp_segmenter u_burst_tlp_segmenter (
    .clk(clk), .rst_n(rst_n), .mps_sel(mps_sel), .s_address(s_address),
    .s_burstcount(s_burstcount), .s_write(s_write), .s_writedata(s_writedata),
    .s_byteenable(s_byteenable), .s_waitrequest(s_waitrequest),
    .s_burst_err(s_burst_err), .m_data(m_data), .m_valid(m_valid),
    .m_sop(m_sop), .m_eop(m_eop), .m_ready(m_ready)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] beat_data(input logic [31:0] tag, input int j);
    return {tag, 32'(j), ~tag, ~32'(j)};
  endfunction

  function automatic logic [15:0] beat_be(input int j, input int cnt, input logic [15:0] fbe, input logic [15:0] lbe);
    if (j == cnt - 1) return lbe;
    if (j == 0) return fbe;
    return 16'hffff;
  endfunction

  task automatic push_burst(input logic [63:0] addr, input int cnt, input logic [15:0] fbe,
                            input logic [15:0] lbe, input logic [31:0] tag);
    int mpsb, i, n, f, l, len;
    logic [59:0] b0, pb;
    logic [15:0] bf, bl;
    logic [63:0] pa;
    logic [3:0] fn, ln;
    item_t it;
    mpsb = (mps_sel == 2'd0) ? 8 : (mps_sel == 2'd1) ? 16 : 32;
    b0 = addr[63:4];
    i = 0;
    while (i < cnt) begin
      pb = b0 + 60'(i);
      n = 0;
      do n++; while (i + n < cnt && n < mpsb && ((b0 + 60'(i + n)) & 60'hff) != 0);
      bf = beat_be(i, cnt, fbe, lbe);
      bl = beat_be(i + n - 1, cnt, fbe, lbe);
      f = 0;
      for (int k = 3; k >= 0; k--) if (bf[4*k +: 4] != 4'h0) f = k;
      l = 3;
      for (int k = 0; k < 4; k++) if (bl[4*k +: 4] != 4'h0) l = k;
      len = n * 4 - f - (3 - l);
      pa = {pb, 4'h0} + 64'(4 * f);
      fn = bf[4*f +: 4];
      ln = (len == 1) ? 4'h0 : bl[4*l +: 4];
      it.sop = 1'b1;
      it.eop = 1'b0;
      if (pa[63:32] != 32'h0)
        it.d = {pa[31:0], pa[63:32], 24'h0, ln, fn, 3'b011, 5'h0, 14'h0, 10'(len)};
      else
        it.d = {32'h0, pa[31:0], 24'h0, ln, fn, 3'b010, 5'h0, 14'h0, 10'(len)};
      exp_q.push_back(it);
      for (int j = 0; j < n; j++) begin
        it.sop = 1'b0;
        it.eop = (j == n - 1);
        it.d = beat_data(tag, i + j);
        exp_q.push_back(it);
      end
      i += n;
    end
  endtask

  task automatic run(input logic [63:0] addr, input int cnt, input logic [15:0] fbe,
                     input logic [15:0] lbe, input logic [31:0] tag);
    int nb;
    nb = (cnt == 0) ? 1 : cnt;
    if (cnt == 0 || cnt > 32) exp_err++;
    else push_burst(addr, cnt, fbe, lbe, tag);
    for (int j = 0; j < nb; j++) begin
      s_write      = 1'b1;
      s_address    = (j == 0) ? addr : ~addr;
      s_burstcount = (j == 0) ? 6'(cnt) : 6'd63;
      s_writedata  = beat_data(tag, j);
      s_byteenable = beat_be(j, nb, fbe, lbe);
      while (s_waitrequest) @(negedge clk);
      @(negedge clk);
    end
    s_write = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] lf;
    lf = 8'h5b;
    m_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      m_ready = bp ? (lf[0] | lf[2]) : 1'b1;
    end
  end

  // Scoreboard monitor: R6 R7 R3 R4 R8 R9
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (s_burst_err) got_err++;
      if (m_valid) check(s_waitrequest == 1'b1, "R9 wait-request while emitting", 128'(s_waitrequest), 128'd1);
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected beat", m_data, 128'h0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(m_sop == e.sop, "R8 sop flag", 128'(m_sop), 128'(e.sop));
          check(m_eop == e.eop, "R8 eop flag", 128'(m_eop), 128'(e.eop));
          if (e.sop) begin
            check(m_data[31:24] == e.d[31:24], "R6 format and type", 128'(m_data[31:24]), 128'(e.d[31:24]));
            check(m_data[9:0] == e.d[9:0], "R4 length", 128'(m_data[9:0]), 128'(e.d[9:0]));
            check(m_data[39:32] == e.d[39:32], "R7 byte enables", 128'(m_data[39:32]), 128'(e.d[39:32]));
            check(m_data[127:64] == e.d[127:64], "R3 packet address", 128'(m_data[127:64]), 128'(e.d[127:64]));
          end else begin
            check(m_data == e.d, "R8 payload", m_data, e.d);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_write = 1'b0;
    s_address = '0;
    s_burstcount = '0;
    s_writedata = '0;
    s_byteenable = '0;
    mps_sel = 2'd1;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R10 m_valid in reset", 128'(m_valid), 128'd0);
    check(s_waitrequest == 1'b0, "R10 wait-request in reset", 128'(s_waitrequest), 128'd0);
    check(s_burst_err == 1'b0, "R10 error in reset", 128'(s_burst_err), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0 && s_waitrequest == 1'b0, "R10 idle after reset", 128'({m_valid, s_waitrequest}), 128'd0);

    run(64'h1000, 2, 16'hffff, 16'hffff, 32'h11);            // R4 short burst
    settle();
    run(64'h2000, 3, 16'hfff0, 16'h00f3, 32'h22);            // R7 partial dwords, length 9
    settle();
    run(64'h4000, 16, 16'hffff, 16'hffff, 32'h33);           // R4 exactly maximum payload
    settle();
    run(64'h8000, 20, 16'hffff, 16'hffff, 32'h44);           // R3 split 16 + 4
    settle();
    bp = 1'b1;                                               // R9 back-pressure from here on
    run(64'h1_0000_2000, 4, 16'hff00, 16'h0fff, 32'h55);     // R6 4-dword header
    settle();
    run(64'hffff_fff0, 2, 16'hffff, 16'hffff, 32'h56);       // R5 R6 3-dword then 4-dword
    settle();
    run(64'h0fc0, 8, 16'hffff, 16'hffff, 32'h66);            // R5 cut at 4 KB
    settle();
    run(64'h3000, 2, 16'hffff, 16'hffff, 32'h77);            // R8 no merge of adjacent bursts
    run(64'h3020, 2, 16'hffff, 16'hffff, 32'h78);
    settle();
    run(64'h6000, 1, 16'h000f, 16'h000f, 32'h88);            // R7 single dword, last BE 0000
    settle();
    run(64'h6040, 1, 16'h0f00, 16'h0f00, 32'h89);            // R7 single dword inside a beat
    settle();
    run(64'h5007, 2, 16'hffff, 16'hffff, 32'h99);            // R2 low address bits ignored
    settle();
    mps_sel = 2'd0;
    run(64'ha000, 32, 16'hffff, 16'hffff, 32'haa);           // R3 128-byte limit, four packets
    settle();
    mps_sel = 2'd2;
    run(64'hc000, 32, 16'hffff, 16'hffff, 32'hbb);           // R3 512-byte limit, one packet
    settle();
    mps_sel = 2'd3;
    run(64'hd000, 32, 16'hfff0, 16'h0fff, 32'hbc);           // R3 R4 R7 code 3 acts as 512
    settle();
    mps_sel = 2'd1;
    run(64'he000, 40, 16'hffff, 16'hffff, 32'hcc);           // R1 over-long burst rejected
    run(64'he000, 0, 16'hffff, 16'hffff, 32'hcd);            // R1 zero count rejected
    run(64'hf000, 2, 16'hffff, 16'hffff, 32'hdd);            // R1 recovery afterwards
    settle();
    check(got_err == exp_err, "R1 rejection pulses", 128'(got_err), 128'(exp_err));
    check(exp_q.size() == 0, "R8 all expected beats seen", 128'(exp_q.size()), 128'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule